// File: doc/BRIEF.md
# Write-Through Bypassing Register File

This block is a general-purpose register file for a pipelined datapath. It holds `NUM_REGS` entries of `DATA_W` bits, 32 by 32 by default. It has two read ports and one write port. Reads are combinational: each output follows its address with no clock edge in between. The write lands in storage on the rising clock edge when the write enable is high.

Writeback and decode often touch the same register in the same cycle. In that case the read ports return the value being written, not the old stored value. A reader in that cycle sees the write as if it finished early in the cycle, before the read. This removes the conflict between the stage that retires a result and the stage that fetches operands. The two read ports choose this path independently of each other.

Entry 0 is a constant-zero register. After reset, every entry reads as zero.

Top module: `bypass_regfile`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and at any time after it until written, every register reads as zero on both ports.
- R2: With `wr_en` high at a rising clock edge and `wr_addr` nonzero, the entry at `wr_addr` holds `wr_data` from that edge on. Either port then returns that value for that address.
- R3: With `wr_en` low at a rising edge, no entry changes.
- R4: Address 0 always reads as all zeros on both ports. A write to address 0 is discarded, including in the cycle of the write.
- R5: When `wr_en` is high, `wr_addr` is nonzero and equals a port's read address, that port returns `wr_data` in the same cycle, before the clock edge.
- R6: The same-cycle forwarding of R5 is decided per port. Both ports may read the register being written and both return `wr_data`. One port may match while the other reads a different entry.
- R7: A port whose address differs from `wr_addr` returns the stored value of its own entry, whatever is being written.
- R8: When `wr_en` is low, a port whose address equals `wr_addr` returns the stored value, not `wr_data`.
- R9: A change of a read address changes that port's output within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all entries |
| rd_addr_a | input | ADDR_W (5) | Read address, port A |
| rd_data_a | output | DATA_W (32) | Read data, port A |
| rd_addr_b | input | ADDR_W (5) | Read address, port B |
| rd_data_b | output | DATA_W (32) | Read data, port B |
| wr_en | input | 1 | Write enable |
| wr_addr | input | ADDR_W (5) | Write address |
| wr_data | input | DATA_W (32) | Write data |

## Verification
The bench tests a write and a read of the same entry in one cycle on both ports at once. A file without forwarding would return the stale value there. It also tests one port matching the write address while the other does not, which exposes a shared or crossed forwarding select. It writes and reads entry 0 in one cycle, where a design that forwards before its zero check would leak the written data. It matches addresses with the enable low, where a design that ignores the enable on the forwarding path would show data that never lands. Finally, it moves read addresses mid-cycle and asserts reset mid-run, which catches registered read paths and missed clears.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;

  typedef enum logic [1:0] {
    SRC_ZERO   = 2'd0,
    SRC_BYPASS = 2'd1,
    SRC_ARRAY  = 2'd2
  } rd_src_e;

  // Priority: the constant-zero entry wins over forwarding, forwarding over storage.
  function automatic rd_src_e pick_source(input logic addr_is_zero, input logic fwd_hit);
    if (addr_is_zero)  return SRC_ZERO;
    else if (fwd_hit)  return SRC_BYPASS;
    else               return SRC_ARRAY;
  endfunction

endpackage

// File: rtl/rf_write_ctrl.sv
`timescale 1ns/1ps
module rf_write_ctrl #(
  parameter int NUM_REGS = 32,
  localparam int ADDR_W = $clog2(NUM_REGS)
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [NUM_REGS-1:0] wr_sel
);

  // One select line per entry; entry 0 never selected.
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    if (i == 0) begin : g_zero
      assign wr_sel[i] = 1'b0;
    end else begin : g_live
      assign wr_sel[i] = wr_en && (wr_addr == ADDR_W'(i));
    end
  end

endmodule

// File: rtl/rf_storage.sv
`timescale 1ns/1ps
module rf_storage #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_REGS-1:0]              wr_sel,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  entries
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
    if (i == 0) begin : g_const
      assign entries[i] = '0;
    end else begin : g_flop
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         q <= '0;
        else if (wr_sel[i]) q <= wr_data;
      end
      assign entries[i] = q;
    end
  end

endmodule

// File: rtl/rf_read_port.sv
`timescale 1ns/1ps
module rf_read_port
  import rf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic [ADDR_W-1:0]                rd_addr,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  entries,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  output logic                             fwd_hit,
  output logic [DATA_W-1:0]                rd_data
);

  logic    addr_zero;
  rd_src_e src;

  assign addr_zero = (rd_addr == '0);
  assign fwd_hit   = wr_en && (wr_addr == rd_addr) && !addr_zero;
  assign src       = pick_source(addr_zero, fwd_hit);

  always_comb begin
    unique case (src)
      SRC_ZERO:   rd_data = '0;
      SRC_BYPASS: rd_data = wr_data;
      default:    rd_data = entries[rd_addr];
    endcase
  end

endmodule

// File: rtl/bypass_regfile.sv
`timescale 1ns/1ps
module bypass_regfile #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);

  localparam int NUM_RD = 2;

  logic [NUM_REGS-1:0]             wr_sel;
  logic [NUM_REGS-1:0][DATA_W-1:0] entries;
  logic [NUM_RD-1:0][ADDR_W-1:0]   rd_addr_v;
  logic [NUM_RD-1:0][DATA_W-1:0]   rd_data_v;
  logic [NUM_RD-1:0]               byp_hit;

  assign rd_addr_v[0] = rd_addr_a;
  assign rd_addr_v[1] = rd_addr_b;
  assign rd_data_a    = rd_data_v[0];
  assign rd_data_b    = rd_data_v[1];

  rf_write_ctrl #(.NUM_REGS(NUM_REGS)) u_wctl (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_sel  (wr_sel)
  );

  rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .entries (entries)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_port (
      .rd_addr (rd_addr_v[p]),
      .entries (entries),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .fwd_hit (byp_hit[p]),
      .rd_data (rd_data_v[p])
    );
  end

endmodule

// File: rtl/bypass_regfile_chk.sv
`timescale 1ns/1ps
module bypass_regfile_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] rd_addr_a,
  input logic [DATA_W-1:0] rd_data_a,
  input logic [ADDR_W-1:0] rd_addr_b,
  input logic [DATA_W-1:0] rd_data_b,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [1:0]        byp_hit
);

  logic seen_edge = 1'b0;
  always_ff @(posedge clk) seen_edge <= 1'b1;

  p_reset_zero_r1: assert property (@(posedge clk)
    (seen_edge && !rst_n && !wr_en) |-> (rd_data_a == '0 && rd_data_b == '0));

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(wr_addr) != '0 && rd_addr_a == $past(wr_addr) && !byp_hit[0])
    |-> rd_data_a == $past(wr_data));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && rd_addr_a == $past(rd_addr_a) && !byp_hit[0] && !$past(byp_hit[0]))
    |-> $stable(rd_data_a));

  p_zero_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_a == '0 || rd_addr_b == '0)
    |-> ((rd_addr_a != '0 || rd_data_a == '0) && (rd_addr_b != '0 || rd_data_b == '0)));

  p_bypass_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byp_hit[0] |-> rd_data_a == wr_data);

  p_bypass_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byp_hit[1] |-> rd_data_b == wr_data);

endmodule

bind bypass_regfile bypass_regfile_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_addr_a (rd_addr_a),
  .rd_data_a (rd_data_a),
  .rd_addr_b (rd_addr_b),
  .rd_data_b (rd_data_b),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .byp_hit   (byp_hit)
);

// File: tb/bypass_regfile_bench.sv
`timescale 1ns/1ps
module bypass_regfile_bench;

  localparam int NR = 32;
  localparam int AW = 5;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] rd_data_a, rd_data_b;

  always #4 clk = ~clk;   // 125 MHz

  bypass_regfile u_bypass_regfile (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  typedef struct {
    string         req;
    logic [AW-1:0] ra;
    logic [AW-1:0] rb;
    logic [DW-1:0] ea;
    logic [DW-1:0] eb;
  } exp_t;

  exp_t          sbq[$];
  event          ev_chk;
  int            n_run = 0;
  int            n_fail = 0;
  logic [DW-1:0] model [NR];

  function automatic logic [DW-1:0] pat(input int i);
    return 32'hC3A5_0000 ^ (i * 32'h0001_0203) ^ {i[7:0], 24'h0};
  endfunction

  // Expected read value from the requirements: zero entry, then forwarding, then storage.
  function automatic logic [DW-1:0] predict(input logic [AW-1:0] ra);
    if (ra == '0)                     return '0;
    if (wr_en && wr_addr == ra)       return wr_data;
    return model[ra];
  endfunction

  task automatic push(input string req);
    exp_t e;
    e.req = req; e.ra = rd_addr_a; e.rb = rd_addr_b;
    e.ea = predict(rd_addr_a); e.eb = predict(rd_addr_b);
    sbq.push_back(e);
    ->ev_chk;
  endtask

  // Monitor: samples 1 ns after each push, well away from the clock edge.
  initial begin
    forever begin
      @(ev_chk);
      #1;
      while (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        n_run++;
        if (rd_data_a !== e.ea) begin
          n_fail++;
          $display("FAIL %s port A addr %0d: actual %h expected %h", e.req, e.ra, rd_data_a, e.ea);
        end
        n_run++;
        if (rd_data_b !== e.eb) begin
          n_fail++;
          $display("FAIL %s port B addr %0d: actual %h expected %h", e.req, e.rb, rd_data_b, e.eb);
        end
      end
    end
  end

  // Driver: called at a falling edge, returns at the next falling edge.
  task automatic cycle(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                       input logic [AW-1:0] ra, input logic [AW-1:0] rb, input string req);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr_a = ra; rd_addr_b = rb;
    push(req);
    @(posedge clk);
    if (rst_n && we && wa != '0) model[wa] = wd;
    @(negedge clk);
  endtask

  // Mid-cycle address change with no write: checks the combinational read path.
  task automatic probe(input logic [AW-1:0] ra, input logic [AW-1:0] rb, input string req);
    #2;
    wr_en = 1'b0; rd_addr_a = ra; rd_addr_b = rb;
    push(req);
    @(negedge clk);
  endtask

  task automatic clear_model();
    for (int i = 0; i < NR; i++) model[i] = '0;
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog: actual run still busy, expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    clear_model();
    @(negedge clk);
    @(negedge clk);
    // R1: reset state on both ports
    cycle(1'b0, 5'd0, '0, 5'd5, 5'd31, "R1");
    probe(5'd17, 5'd1, "R1");
    rst_n = 1'b1;
    @(negedge clk);

    // R2 and R5: fill every entry; port A reads the previous entry, port B the one being written
    for (int i = 1; i < NR; i++)
      cycle(1'b1, AW'(i), pat(i), AW'(i - 1), AW'(i), "R2");

    // R2: read back every entry
    for (int i = 0; i < NR; i++)
      cycle(1'b0, 5'd0, '0, AW'(i), AW'(NR - 1 - i), "R2");

    // R8: matching address with enable low shows stored value
    cycle(1'b0, 5'd7, 32'hDEAD_BEEF, 5'd7, 5'd7, "R8");
    // R3: nothing changed
    cycle(1'b0, 5'd0, '0, 5'd7, 5'd8, "R3");

    // R4: write to entry 0 while both ports read it, then read it again
    cycle(1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd0, "R4");
    cycle(1'b0, 5'd0, '0, 5'd0, 5'd3, "R4");

    // R6: both ports read the entry being written
    cycle(1'b1, 5'd12, 32'h1234_5678, 5'd12, 5'd12, "R6");
    cycle(1'b1, 5'd31, 32'h8000_0001, 5'd31, 5'd31, "R6");
    // R6: one port matches, the other does not
    cycle(1'b1, 5'd20, 32'h0BAD_F00D, 5'd20, 5'd21, "R6");
    cycle(1'b1, 5'd21, 32'h7777_0000, 5'd22, 5'd21, "R6");
    // R7: neither port matches the write
    cycle(1'b1, 5'd10, 32'hAAAA_5555, 5'd11, 5'd12, "R7");
    cycle(1'b0, 5'd0, '0, 5'd10, 5'd20, "R2");

    // R9: addresses move within one cycle
    cycle(1'b0, 5'd0, '0, 5'd1, 5'd2, "R9");
    probe(5'd30, 5'd29, "R9");

    // R5: mixed traffic with frequent address matches
    for (int k = 0; k < 400; k++) begin
      logic [AW-1:0] wa, ra, rb;
      wa = AW'($urandom_range(0, NR - 1));
      ra = ($urandom_range(0, 2) == 0) ? wa : AW'($urandom_range(0, NR - 1));
      rb = ($urandom_range(0, 2) == 0) ? wa : AW'($urandom_range(0, NR - 1));
      cycle(1'($urandom_range(0, 1)), wa, $urandom(), ra, rb, "R5");
    end

    // R1: reset asserted mid-run clears everything
    rst_n = 1'b0;
    clear_model();
    cycle(1'b0, 5'd0, '0, 5'd12, 5'd31, "R1");
    rst_n = 1'b1;
    cycle(1'b0, 5'd0, '0, 5'd20, 5'd10, "R1");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule